// File: doc/BRIEF.md
# Page Permission Checker with Fault Status Capture

This block sits behind a reference-style page-table walker. Once the walk has produced a final page-table entry, or has stopped on a bad descriptor, the walker presents the result for a single cycle with `chk_valid`. The checker forms a 3-bit access index from the kind of access. It looks up that index against the entry's 3-bit access-control field and returns a permission code. It also returns read and write grants for the translation cache to use. A write grant is held back until the entry's modified bit is already set, so the first store to a clean page takes a second pass through the walker, which marks the page dirty.

Any error, whether from the permission lookup or from the walk, is recorded in a fault status register and a fault address register. Software reads both. A read strobe on the status register clears it. If a second fault arrives before software has read the first one, the status register keeps an overflow mark. A no-fault control input turns every error into a full read and write grant. The fault is still recorded.

Top module: `mmu_perm_fsr`

## Requirements
- R1: The access index is {write, fetch, supervisor}: bit 2 is `acc_write`, bit 1 is `acc_fetch`, bit 0 is `acc_super`. It is recorded in status bits [7:5].
- R2: With `walk_ftype` = 0, `err_code[1:0]` is 0 when the access is allowed and 2 on a protection error. Bits [9:2] are 0. By ACC value, user reads are allowed for {0,1,2,3,5}, supervisor reads for all except 4, user fetches for {2,3,4}, supervisor fetches for {2,3,4,6,7}, user writes for {1,3} and supervisor writes for {1,3,5,7}. An access that is both a write and a fetch needs both rights.
- R3: A user-mode access (index bit 0 = 0) to ACC 6 or 7 gives code 3 (privilege violation), whatever the other index bits are.
- R4: With a zero `err_code`, `grant_read` is 1. `grant_write` is 1 only when `pte_modified` is 1 and ACC is in {1,3} for user mode or {1,3,5,7} for supervisor mode.
- R5: With a nonzero `err_code`, both grants are 0 when `ctrl_nofault` is 0 and both are 1 when it is 1.
- R6: A nonzero `walk_ftype` (1 = invalid, 4 = reserved) overrides the permission lookup. In that case `err_code` = {`walk_level` in [9:8], 3'b0, `walk_ftype` in [4:2], 2'b00}.
- R7: A fault is `chk_valid` with a nonzero `err_code`. At the next edge the status register loads {level [9:8], index [7:5], type [4:2], 1 in bit 1 (address valid), overflow in bit 0}. The type is `walk_ftype` for walk faults and the permission code (2 or 3) otherwise. The level field is `walk_level` in both cases.
- R8: If the status register is nonzero at a fault and is not being read in that cycle, bit 0 of the new value is 1 and the older fields are replaced.
- R9: The fault address register loads the full `vaddr` on every fault, including faults in no-fault mode.
- R10: `fsr_rd` clears the status register at the next edge. A fault in the same cycle as a read wins, and its overflow bit is 0.
- R11: Without a fault and without a read, both registers hold their values. An allowed check changes neither.
- R12: After reset both registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | A completed walk result is presented this cycle |
| acc | input | 3 | Access-control field of the final entry |
| pte_modified | input | 1 | Modified bit of the final entry |
| acc_write | input | 1 | Access is a store |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is made in supervisor mode |
| vaddr | input | 32 | Virtual address of the access |
| walk_level | input | 2 | Table level at which the walk ended |
| walk_ftype | input | 3 | Walk fault type: 0 none, 1 invalid, 4 reserved |
| ctrl_nofault | input | 1 | No-fault mode control bit |
| fsr_rd | input | 1 | Software read of the status register (clears it) |
| err_code | output | 10 | Error code of the current check |
| grant_read | output | 1 | Read may be mapped |
| grant_write | output | 1 | Write may be mapped |
| fsr | output | 10 | Fault status register |
| far | output | 32 | Fault address register |

## Verification
The assertions assume that `walk_ftype` only ever takes the values 0, 1 or 4, and that `walk_level` and the access fields are driven to known values whenever `chk_valid` is high. The bench drives only those walk fault types. It sets every field before the strobe and holds it through the sampling edge. The sweep covers all 64 combinations of index and ACC under both modified states and both no-fault states. Separate sequences cover back-to-back faults with no read in between and a fault that lands in the same cycle as a read. In every other vector the bench clears the status register first, so overflow appears only where the bench has set it up on purpose.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

    localparam int ACC_W  = 3;
    localparam int IDX_W  = 3;
    localparam int LVL_W  = 2;
    localparam int FT_W   = 3;
    localparam int CODE_W = 2;
    localparam int ERR_W  = 10;
    localparam int FSR_W  = 10;
    localparam int NACC   = 1 << ACC_W;

    // Bit a of each mask means "ACC value a grants this right".
    localparam logic [NACC-1:0] USR_RD_MASK = 8'h2F;  // 0,1,2,3,5
    localparam logic [NACC-1:0] SUP_RD_MASK = 8'hEF;  // all but 4
    localparam logic [NACC-1:0] USR_EX_MASK = 8'h1C;  // 2,3,4
    localparam logic [NACC-1:0] SUP_EX_MASK = 8'hDC;  // 2,3,4,6,7
    localparam logic [NACC-1:0] USR_WR_MASK = 8'h0A;  // 1,3
    localparam logic [NACC-1:0] SUP_WR_MASK = 8'hAA;  // 1,3,5,7
    localparam logic [NACC-1:0] SUP_ONLY    = 8'hC0;  // 6,7

    typedef enum logic [CODE_W-1:0] {
        PC_OK    = 2'd0,
        PC_RSVD  = 2'd1,
        PC_PROT  = 2'd2,
        PC_PRIV  = 2'd3
    } perm_code_e;

    typedef struct packed {
        logic [FSR_W-1:0] fsr;
        logic [31:0]      far;
    } rec_state_t;

endpackage

// File: rtl/mmu_perm_eval.sv
module mmu_perm_eval
    import mmu_perm_pkg::*;
(
    input  logic [ACC_W-1:0]  acc,
    input  logic              pte_modified,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_super,
    input  logic [LVL_W-1:0]  walk_level,
    input  logic [FT_W-1:0]   walk_ftype,
    input  logic              ctrl_nofault,
    output logic [ERR_W-1:0]  err_code,
    output logic              grant_read,
    output logic              grant_write,
    output logic [IDX_W-1:0]  acc_idx,
    output logic [FT_W-1:0]   fault_type,
    output logic              is_err
);

    logic             rd_ok, ex_ok, wr_ok, allowed;
    perm_code_e       pcode;
    logic             walk_err;

    assign acc_idx = {acc_write, acc_fetch, acc_super};

    always_comb begin
        rd_ok = acc_super ? SUP_RD_MASK[acc] : USR_RD_MASK[acc];
        ex_ok = acc_super ? SUP_EX_MASK[acc] : USR_EX_MASK[acc];
        wr_ok = acc_super ? SUP_WR_MASK[acc] : USR_WR_MASK[acc];

        allowed = (!acc_write || wr_ok) &&
                  (!acc_fetch || ex_ok) &&
                  (acc_write || acc_fetch || rd_ok);

        if (!acc_super && SUP_ONLY[acc])
            pcode = PC_PRIV;
        else if (allowed)
            pcode = PC_OK;
        else
            pcode = PC_PROT;

        walk_err = (walk_ftype != '0);

        if (walk_err) begin
            err_code   = {walk_level, 3'b000, walk_ftype, 2'b00};
            fault_type = walk_ftype;
        end else begin
            err_code   = {{(ERR_W-CODE_W){1'b0}}, pcode};
            fault_type = {{(FT_W-CODE_W){1'b0}}, pcode};
        end

        is_err = walk_err || (pcode != PC_OK);

        if (is_err) begin
            grant_read  = ctrl_nofault;
            grant_write = ctrl_nofault;
        end else begin
            grant_read  = 1'b1;
            grant_write = pte_modified && wr_ok;
        end
    end

endmodule

// File: rtl/mmu_fault_rec.sv
module mmu_fault_rec
    import mmu_perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              fsr_rd,
    input  logic [LVL_W-1:0]  level,
    input  logic [IDX_W-1:0]  idx,
    input  logic [FT_W-1:0]   ftype,
    input  logic [31:0]       vaddr,
    output logic [FSR_W-1:0]  fsr,
    output logic [31:0]       far
);

    rec_state_t st_d, st_q;
    logic       ovf_d;

    always_comb begin
        st_d  = st_q;
        ovf_d = (st_q.fsr != '0) && !fsr_rd;
        if (fault) begin
            st_d.fsr = {level, idx, ftype, 1'b1, ovf_d};
            st_d.far = vaddr;
        end else if (fsr_rd) begin
            st_d.fsr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fsr = st_q.fsr;
    assign far = st_q.far;

endmodule

// File: rtl/mmu_perm_fsr.sv
module mmu_perm_fsr
    import mmu_perm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic [2:0]        acc,
    input  logic              pte_modified,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_super,
    input  logic [31:0]       vaddr,
    input  logic [1:0]        walk_level,
    input  logic [2:0]        walk_ftype,
    input  logic              ctrl_nofault,
    input  logic              fsr_rd,
    output logic [9:0]        err_code,
    output logic              grant_read,
    output logic              grant_write,
    output logic [9:0]        fsr,
    output logic [31:0]       far
);

    logic [IDX_W-1:0] idx_w;
    logic [FT_W-1:0]  ft_w;
    logic             err_w;

    mmu_perm_eval u_eval (
        .acc          (acc),
        .pte_modified (pte_modified),
        .acc_write    (acc_write),
        .acc_fetch    (acc_fetch),
        .acc_super    (acc_super),
        .walk_level   (walk_level),
        .walk_ftype   (walk_ftype),
        .ctrl_nofault (ctrl_nofault),
        .err_code     (err_code),
        .grant_read   (grant_read),
        .grant_write  (grant_write),
        .acc_idx      (idx_w),
        .fault_type   (ft_w),
        .is_err       (err_w)
    );

    mmu_fault_rec u_rec (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault  (chk_valid && err_w),
        .fsr_rd (fsr_rd),
        .level  (walk_level),
        .idx    (idx_w),
        .ftype  (ft_w),
        .vaddr  (vaddr),
        .fsr    (fsr),
        .far    (far)
    );

endmodule

// File: rtl/mmu_perm_fsr_chk.sv
module mmu_perm_fsr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        chk_valid,
    input logic [2:0]  acc,
    input logic        pte_modified,
    input logic        acc_super,
    input logic [31:0] vaddr,
    input logic [1:0]  walk_level,
    input logic [2:0]  walk_ftype,
    input logic        ctrl_nofault,
    input logic        fsr_rd,
    input logic [9:0]  err_code,
    input logic        grant_read,
    input logic        grant_write,
    input logic [9:0]  fsr,
    input logic [31:0] far
);

    logic flt;
    assign flt = chk_valid && (err_code != '0);

    p_fav_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> fsr[1]);

    p_far_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flt |=> far == $past(vaddr));

    p_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flt && fsr != '0 && !fsr_rd) |=> fsr[0]);

    p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fsr_rd && !flt) |=> fsr == '0);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsr_rd && !flt) |=> ($stable(fsr) && $stable(far)));

    p_clean_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pte_modified && !ctrl_nofault) |-> !grant_write);

    p_clean_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code == '0) |-> grant_read);

    p_err_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != '0 && !ctrl_nofault) |-> (!grant_read && !grant_write));

    p_user_priv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_ftype == 3'd0 && !acc_super && acc[2:1] == 2'b11) |-> err_code == 10'd3);

    p_walk_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_ftype != 3'd0) |-> (err_code[4:2] == walk_ftype && err_code[9:8] == walk_level));

endmodule

bind mmu_perm_fsr mmu_perm_fsr_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chk_valid    (chk_valid),
    .acc          (acc),
    .pte_modified (pte_modified),
    .acc_super    (acc_super),
    .vaddr        (vaddr),
    .walk_level   (walk_level),
    .walk_ftype   (walk_ftype),
    .ctrl_nofault (ctrl_nofault),
    .fsr_rd       (fsr_rd),
    .err_code     (err_code),
    .grant_read   (grant_read),
    .grant_write  (grant_write),
    .fsr          (fsr),
    .far          (far)
);

// File: tb/mmu_perm_fsr_tb.sv
module mmu_perm_fsr_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chk_valid = 1'b0;
    logic [2:0]  acc = '0;
    logic        pte_modified = 1'b0;
    logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_super = 1'b0;
    logic [31:0] vaddr = '0;
    logic [1:0]  walk_level = '0;
    logic [2:0]  walk_ftype = '0;
    logic        ctrl_nofault = 1'b0;
    logic        fsr_rd = 1'b0;
    logic [9:0]  err_code;
    logic        grant_read, grant_write;
    logic [9:0]  fsr;
    logic [31:0] far;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;
    logic [31:0] last_far = '0;

    always #10 clk = ~clk;   // 50 MHz

    mmu_perm_fsr u_dut (.*);

    // Expected permission code per access index (row) and ACC value (column).
    localparam bit [1:0] TBL [8][8] = '{
        '{2'd0,2'd0,2'd0,2'd0,2'd2,2'd0,2'd3,2'd3},
        '{2'd0,2'd0,2'd0,2'd0,2'd2,2'd0,2'd0,2'd0},
        '{2'd2,2'd2,2'd0,2'd0,2'd0,2'd2,2'd3,2'd3},
        '{2'd2,2'd2,2'd0,2'd0,2'd0,2'd2,2'd0,2'd0},
        '{2'd2,2'd0,2'd2,2'd0,2'd2,2'd2,2'd3,2'd3},
        '{2'd2,2'd0,2'd2,2'd0,2'd2,2'd0,2'd2,2'd0},
        '{2'd2,2'd2,2'd2,2'd0,2'd2,2'd2,2'd3,2'd3},
        '{2'd2,2'd2,2'd2,2'd0,2'd2,2'd2,2'd2,2'd0}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic bit wperm(input int sup, input int a);
        return sup ? (a % 2 == 1) : (a == 1 || a == 3);
    endfunction

    task automatic drive(input int idx, input int a, input bit m, input bit nf,
                         input logic [1:0] lvl, input logic [2:0] ft, input logic [31:0] va);
        acc_write = idx[2]; acc_fetch = idx[1]; acc_super = idx[0];
        acc = a[2:0]; pte_modified = m; ctrl_nofault = nf;
        walk_level = lvl; walk_ftype = ft; vaddr = va; chk_valid = 1'b1;
    endtask

    task automatic clear_fsr;
        @(negedge clk); chk_valid = 1'b0; fsr_rd = 1'b1;
        @(negedge clk); fsr_rd = 1'b0;
        #2 check(fsr == 10'd0, "R10 read clears", 32'(fsr), 0);
    endtask

    // One permission vector: combinational check, then register check.
    task automatic perm_vec(input int idx, input int a, input bit m, input bit nf);
        logic [1:0]  code;
        logic [31:0] va;
        logic [9:0]  efsr;
        bit          ew;
        code = TBL[idx][a];
        va   = {8'hA5, 5'(idx), 3'(a), m, nf, 14'h1234} ^ 32'(idx * 977 + a * 31);
        @(negedge clk);
        drive(idx, a, m, nf, 2'(a), 3'd0, va);
        #2;
        check(err_code == {8'd0, code}, (a >= 6 && idx[0] == 0) ? "R3 priv code" : "R2 perm code",
              32'(err_code), 32'(code));
        if (code == 2'd0) begin
            ew = m && wperm(idx[0], a);
            check(grant_read == 1'b1, "R4 read grant", 32'(grant_read), 1);
            check(grant_write == ew, "R4 write grant", 32'(grant_write), 32'(ew));
        end else begin
            check(grant_read == nf && grant_write == nf, "R5 grants on error",
                  {grant_read, grant_write}, {nf, nf});
        end
        @(negedge clk);
        chk_valid = 1'b0;
        #2;
        if (code != 2'd0) begin
            efsr = {2'(a), 3'(idx), 1'b0, code, 1'b1, 1'b0};
            check(fsr == efsr, "R7 R1 status fields", 32'(fsr), 32'(efsr));
            check(far == va, "R9 address capture", far, va);
            last_far = va;
            clear_fsr();
        end else begin
            check(fsr == 10'd0 && far == last_far, "R11 no change on allowed check",
                  far, last_far);
        end
    endtask

    initial begin
        #1;
        #44 rst_n = 1'b1;
        @(negedge clk);
        #2 check(fsr == 0 && far == 0, "R12 reset state", far, 0);

        for (int idx = 0; idx < 8; idx++)
            for (int a = 0; a < 8; a++)
                for (int mn = 0; mn < 4; mn++)
                    perm_vec(idx, a, mn[0], mn[1]);

        // R6: walk faults override an otherwise allowed access.
        for (int l = 0; l < 4; l++)
            for (int k = 0; k < 2; k++) begin
                logic [2:0]  ft;
                logic [31:0] va;
                ft = (k == 0) ? 3'd1 : 3'd4;
                va = 32'hC000_0000 + 32'(l * 4096 + k * 8);
                @(negedge clk);
                drive(1, 3, 1'b1, k[0], 2'(l), ft, va);  // super read, ACC 3
                #2;
                check(err_code == {2'(l), 3'b000, ft, 2'b00}, "R6 walk code",
                      32'(err_code), 32'({2'(l), 3'b000, ft, 2'b00}));
                check(grant_read == k[0] && grant_write == k[0], "R5 walk grants",
                      {grant_read, grant_write}, {k[0], k[0]});
                @(negedge clk); chk_valid = 1'b0;
                #2;
                check(fsr == {2'(l), 3'd1, ft, 1'b1, 1'b0}, "R7 walk status", 32'(fsr),
                      32'({2'(l), 3'd1, ft, 1'b1, 1'b0}));
                check(far == va, "R9 walk address", far, va);
                last_far = va;
                clear_fsr();
            end

        // R8: second fault before a read sets overflow and replaces fields.
        @(negedge clk); drive(0, 4, 1'b0, 1'b0, 2'd3, 3'd0, 32'h1111_0000);
        @(negedge clk); drive(4, 6, 1'b0, 1'b0, 2'd2, 3'd0, 32'h2222_0000);
        @(negedge clk); chk_valid = 1'b0;
        #2;
        check(fsr == {2'd2, 3'd4, 3'd3, 1'b1, 1'b1}, "R8 overflow", 32'(fsr),
              32'({2'd2, 3'd4, 3'd3, 1'b1, 1'b1}));
        check(far == 32'h2222_0000, "R9 latest address", far, 32'h2222_0000);

        // R10: fault coinciding with a read loads without overflow.
        @(negedge clk); drive(2, 0, 1'b0, 1'b0, 2'd1, 3'd0, 32'h3333_0000); fsr_rd = 1'b1;
        @(negedge clk); chk_valid = 1'b0; fsr_rd = 1'b0;
        #2;
        check(fsr == {2'd1, 3'd2, 3'd2, 1'b1, 1'b0}, "R10 fault wins over read", 32'(fsr),
              32'({2'd1, 3'd2, 3'd2, 1'b1, 1'b0}));

        // R11: idle cycles hold both registers; R10 read clears afterwards.
        @(negedge clk); @(negedge clk);
        #2 check(fsr == {2'd1, 3'd2, 3'd2, 1'b1, 1'b0} && far == 32'h3333_0000,
                 "R11 hold while idle", far, 32'h3333_0000);
        clear_fsr();
        check(far == 32'h3333_0000, "R11 read leaves address", far, 32'h3333_0000);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule